// File: doc/BRIEF.md
# Conversion Pacing and Hold Controller

This block sets how often an integrating converter takes a reading. It produces a clock enable that the converter's sequencer uses to advance. The enable comes from a set/reset run latch. The sequencer marks the start of each ZERO phase with a one-cycle pulse. That pulse clears the latch, unless the fast-rate setting is active, and a digital delay timer sets it again after a programmed wait. Long waits of many seconds are reached by counting the delay in prescaled ticks.

Three active-low lines let outside equipment synchronise with the converter:

- **Freeze line.** Stops the converter at once, whatever phase it is in. The converter resumes as soon as the line is released.
- **Park line.** Lets the conversion in progress run to its end. The converter then halts at the next ZERO start.
- **Trigger line.** Each falling edge of this line releases exactly one further conversion while the converter is parked.

All three lines are treated as asynchronous and noisy. Each passes through a two-flop synchroniser and a debounce filter before the controller uses it.

Top module: `conv_pace_ctrl`

## Requirements
- R1: After reset the enable output is 1 and all three lines count as released.
- R2: A ZERO start pulse with the park line released and either `max_rate`=1 or `delay_val`=0 leaves the enable at 1 without a gap.
- R3: A ZERO start pulse with the park line released, `max_rate`=0 and `delay_val`=D>0 drives the enable to 0 from the next cycle. The enable stays at 0 for exactly D*TICK_DIV cycles, then returns to 1, provided the freeze line stays released.
- R4: While the conditioned freeze line is asserted, the enable is 0 in every cycle and a running delay count is paused. Releasing the line restores the enable in the same cycle the conditioned level drops.
- R5: A ZERO start pulse while the conditioned park line is asserted drives the enable to 0 from the next cycle. The enable stays at 0 with no time limit.
- R6: While parked, a conditioned falling edge of the trigger line (low = asserted) brings the enable back to 1 in the following cycle, for exactly one conversion. A trigger held low does not start a second one. A trigger edge that arrives while the converter is running is ignored.
- R7: Releasing the park line while parked brings the enable back to 1 in the cycle after the conditioned level drops.
- R8: A change on a raw line that holds steady takes effect on the conditioned level after 2+DEB_CYC clock edges. A pulse shorter than DEB_CYC cycles has no effect.
- R9: Asserting the park line during a delay wait turns the wait into a park. Expiry of the delay timer then no longer restarts the converter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zero_start | input | 1 | One-cycle pulse marking the leading edge of the ZERO phase |
| max_rate | input | 1 | 1 = back-to-back conversions with no delay |
| delay_val | input | DLY_W | Inter-conversion wait, in units of TICK_DIV cycles |
| hold1_n | input | 1 | Raw freeze line, active low, asynchronous |
| hold2_n | input | 1 | Raw park-at-ZERO line, active low, asynchronous |
| trig_n | input | 1 | Raw single-shot trigger line, active low, asynchronous |
| clk_en | output | 1 | Gated clock enable for the converter sequencer |

## Verification
Each result has a fixed point at which it is due:

| Stimulus | When the enable responds |
|----------|--------------------------|
| ZERO start pulse | Enable falls in the cycle right after the edge that samples the pulse; a delay wait then lasts D*TICK_DIV cycles |
| Freeze or park line change | Conditioned level changes 2+DEB_CYC edges after the raw change; the freeze line acts on the enable in that same cycle, the park release one edge later |
| Trigger line | Wake-up appears 3+DEB_CYC edges after the raw falling edge |

The bench runs a behavioural model that advances on each rising edge. It compares the enable with that model on every falling edge, so each comparison falls in the middle of the cycle in which the result is due. Directed checks on top of that count edges from the stimulus to the change and compare the count with these latencies.

// File: rtl/pace_pkg.sv
package pace_pkg;

  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_WAIT_DLY  = 2'd1,
    ST_WAIT_TRIG = 2'd2
  } pace_st_e;

  localparam int NUM_LINES = 3;
  localparam int LN_FREEZE = 0;
  localparam int LN_PARK   = 1;
  localparam int LN_TRIG   = 2;

  // The delay phase is skipped on the fast-rate setting or a zero delay.
  function automatic logic skip_wait(input logic fast_sel, input logic dly_is_zero);
    return fast_sel | dly_is_zero;
  endfunction

  // Number of idle cycles a delay value produces.
  function automatic int unsigned idle_cycles(input int unsigned dly, input int unsigned div);
    return dly * div;
  endfunction

endpackage

// File: rtl/pace_line_cond.sv
module pace_line_cond #(
  parameter int DEB_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic level,
  output logic rise
);
  localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYC - 1);

  logic          sync_a, sync_b;
  logic [CW-1:0] run_cnt;
  logic          lvl_q, lvl_d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a  <= 1'b1;
      sync_b  <= 1'b1;
      run_cnt <= '0;
      lvl_q   <= 1'b0;
      lvl_d1  <= 1'b0;
    end else begin
      sync_a <= raw_n;
      sync_b <= sync_a;
      lvl_d1 <= lvl_q;
      if (~sync_b == lvl_q) begin
        run_cnt <= '0;
      end else if (run_cnt == CNT_LAST) begin
        lvl_q   <= ~sync_b;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  assign level = lvl_q;
  assign rise  = lvl_q & ~lvl_d1;

endmodule

// File: rtl/pace_delay_timer.sv
module pace_delay_timer #(
  parameter int DLY_W    = 16,
  parameter int TICK_DIV = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             count_en,
  output logic             expire
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [DLY_W-1:0] ticks_left;
  logic [PW-1:0]    pre_cnt;
  logic             tick;

  assign tick = (pre_cnt == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ticks_left <= '0;
      pre_cnt    <= '0;
    end else if (load) begin
      ticks_left <= load_val;
      pre_cnt    <= '0;
    end else if (count_en && ticks_left != '0) begin
      if (tick) begin
        pre_cnt    <= '0;
        ticks_left <= ticks_left - 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  assign expire = count_en & tick & (ticks_left == DLY_W'(1));

endmodule

// File: rtl/pace_run_latch.sv
module pace_run_latch
  import pace_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic zero_start,
  input  logic skip,
  input  logic park_lvl,
  input  logic trig_evt,
  input  logic tmr_expire,
  output logic tmr_load,
  output logic in_delay,
  output logic run_q
);
  pace_st_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (zero_start) begin
          if (park_lvl) begin
            st_d = ST_WAIT_TRIG;
          end else if (!skip) begin
            st_d     = ST_WAIT_DLY;
            tmr_load = 1'b1;
          end
        end
      end
      ST_WAIT_DLY: begin
        if (park_lvl) begin
          st_d = trig_evt ? ST_RUN : ST_WAIT_TRIG;
        end else if (tmr_expire) begin
          st_d = ST_RUN;
        end
      end
      ST_WAIT_TRIG: begin
        if (trig_evt || !park_lvl) st_d = ST_RUN;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  assign run_q    = (st_q == ST_RUN);
  assign in_delay = (st_q == ST_WAIT_DLY);

endmodule

// File: rtl/conv_pace_ctrl.sv
module conv_pace_ctrl
  import pace_pkg::*;
#(
  parameter int DLY_W    = 16,
  parameter int TICK_DIV = 1000,
  parameter int DEB_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero_start,
  input  logic             max_rate,
  input  logic [DLY_W-1:0] delay_val,
  input  logic             hold1_n,
  input  logic             hold2_n,
  input  logic             trig_n,
  output logic             clk_en
);
  logic [NUM_LINES-1:0] raw_lines, lvl_lines, rise_lines;

  // Named internal events, observed by the bound checker.
  logic freeze_lvl, park_lvl, trig_evt;
  logic tmr_load, tmr_expire, in_delay, run_q, skip;

  assign raw_lines[LN_FREEZE] = hold1_n;
  assign raw_lines[LN_PARK]   = hold2_n;
  assign raw_lines[LN_TRIG]   = trig_n;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    pace_line_cond #(.DEB_CYC(DEB_CYC)) u_cond (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_n (raw_lines[g]),
      .level (lvl_lines[g]),
      .rise  (rise_lines[g])
    );
  end

  assign freeze_lvl = lvl_lines[LN_FREEZE];
  assign park_lvl   = lvl_lines[LN_PARK];
  assign trig_evt   = rise_lines[LN_TRIG];
  assign skip       = skip_wait(max_rate, delay_val == '0);

  pace_run_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .zero_start (zero_start),
    .skip       (skip),
    .park_lvl   (park_lvl),
    .trig_evt   (trig_evt),
    .tmr_expire (tmr_expire),
    .tmr_load   (tmr_load),
    .in_delay   (in_delay),
    .run_q      (run_q)
  );

  pace_delay_timer #(.DLY_W(DLY_W), .TICK_DIV(TICK_DIV)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (delay_val),
    .count_en (in_delay & ~freeze_lvl),
    .expire   (tmr_expire)
  );

  assign clk_en = run_q & ~freeze_lvl;

endmodule

// File: rtl/conv_pace_ctrl_chk.sv
module conv_pace_ctrl_chk #(
  parameter int DLY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             zero_start,
  input logic             max_rate,
  input logic [DLY_W-1:0] delay_val,
  input logic             clk_en,
  input logic             freeze_lvl,
  input logic             park_lvl,
  input logic             trig_evt,
  input logic             tmr_expire,
  input logic             run_q
);
  AST_FREEZE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_lvl |-> !clk_en); // R4
  AST_FAST_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_start && run_q && !park_lvl && (max_rate || delay_val == '0)) |=> run_q); // R2
  AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_start && run_q && !park_lvl && !max_rate && delay_val != '0) |=> !clk_en); // R3
  AST_PARK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_start && run_q && park_lvl) |=> !clk_en); // R5
  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |=> !trig_evt); // R6
  AST_TRIG_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && park_lvl && trig_evt) |=> run_q); // R6
  AST_PARK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && park_lvl && !trig_evt) |=> !run_q); // R9
  AST_EXPIRE_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expire |-> (!run_q && !freeze_lvl)); // R3
endmodule

bind conv_pace_ctrl conv_pace_ctrl_chk #(.DLY_W(DLY_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .zero_start (zero_start),
  .max_rate   (max_rate),
  .delay_val  (delay_val),
  .clk_en     (clk_en),
  .freeze_lvl (freeze_lvl),
  .park_lvl   (park_lvl),
  .trig_evt   (trig_evt),
  .tmr_expire (tmr_expire),
  .run_q      (run_q)
);

// File: tb/conv_pace_ctrl_bench.sv
module conv_pace_ctrl_bench;
  localparam int DLY_W    = 8;
  localparam int TICK_DIV = 2;
  localparam int DEB_CYC  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zero_start = 1'b0;
  logic max_rate = 1'b0;
  logic [DLY_W-1:0] delay_val = '0;
  logic hold1_n = 1'b1;
  logic hold2_n = 1'b1;
  logic trig_n = 1'b1;
  logic clk_en;

  always #2 clk = ~clk;

  conv_pace_ctrl #(.DLY_W(DLY_W), .TICK_DIV(TICK_DIV), .DEB_CYC(DEB_CYC)) u_conv_pace_ctrl (
    .clk(clk), .rst_n(rst_n), .zero_start(zero_start), .max_rate(max_rate),
    .delay_val(delay_val), .hold1_n(hold1_n), .hold2_n(hold2_n), .trig_n(trig_n),
    .clk_en(clk_en)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // mode: 0 running, 1 timed wait, 2 parked waiting for trigger
  int m_mode = 0;
  int m_rem = 0;
  bit m_frz = 0, m_park = 0, m_trg = 0, m_tevt = 0;
  bit q_frz[$], q_park[$], q_trg[$];

  // Conditioned level flips once the asserted-sense samples seen by the
  // filter (taken two edges late) all disagree with it for DEB_CYC edges.
  function automatic bit filt(ref bit q[$], input bit raw_n, input bit lvl);
    int n;
    bit all_diff;
    q.push_back(!raw_n);
    if (q.size() > DEB_CYC + 6) void'(q.pop_front());
    n = q.size();
    if (n < DEB_CYC + 2) return lvl;
    all_diff = 1'b1;
    for (int j = 2; j <= DEB_CYC + 1; j++)
      if (q[n-1-j] == lvl) all_diff = 1'b0;
    return all_diff ? !lvl : lvl;
  endfunction

  always @(posedge clk) begin
    bit nf, np, nt;
    if (!rst_n) begin
      m_mode = 0; m_rem = 0;
      m_frz = 0; m_park = 0; m_trg = 0; m_tevt = 0;
      q_frz.delete(); q_park.delete(); q_trg.delete();
    end else begin
      case (m_mode)
        0: if (zero_start) begin
             if (m_park) m_mode = 2;
             else if (!(max_rate || delay_val == 0)) begin
               m_mode = 1;
               m_rem = int'(delay_val) * TICK_DIV;
             end
           end
        1: if (m_park) m_mode = m_tevt ? 0 : 2;
           else if (!m_frz) begin
             m_rem--;
             if (m_rem == 0) m_mode = 0;
           end
        default: if (m_tevt || !m_park) m_mode = 0;
      endcase
      nf = filt(q_frz, hold1_n, m_frz);
      np = filt(q_park, hold2_n, m_park);
      nt = filt(q_trg, trig_n, m_trg);
      m_tevt = nt && !m_trg;
      m_frz = nf; m_park = np; m_trg = nt;
    end
  end

  // compare every cycle, mid-cycle
  always @(negedge clk) begin
    bit exp_en;
    if (!finished) begin
      exp_en = (m_mode == 0) && !m_frz;
      chk(clk_en === exp_en, cur_req, int'(clk_en), int'(exp_en));
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      chk(1'b0, "watchdog", cyc, 100000);
      summary();
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_zero();
    @(negedge clk) zero_start = 1'b1;
    @(negedge clk) zero_start = 1'b0;
  endtask

  // counts negedges from now until clk_en equals want
  task automatic edges_until(input bit want, output int n);
    n = 0;
    while (clk_en !== want && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    cur_req = "R1";
    chk(clk_en == 1'b1, "R1", int'(clk_en), 1);

    // R2: fast setting and zero delay both skip the wait
    cur_req = "R2";
    max_rate = 1'b1; delay_val = 8'd5;
    pulse_zero();
    chk(clk_en == 1'b1, "R2", int'(clk_en), 1);
    wait_n(4);
    chk(clk_en == 1'b1, "R2", int'(clk_en), 1);
    max_rate = 1'b0; delay_val = 8'd0;
    pulse_zero();
    wait_n(3);
    chk(clk_en == 1'b1, "R2", int'(clk_en), 1);

    // R3: timed wait length
    cur_req = "R3";
    delay_val = 8'd3;
    pulse_zero();
    edges_until(1'b1, n);
    chk(n == 3 * TICK_DIV, "R3", n, 3 * TICK_DIV);
    delay_val = 8'd7;
    pulse_zero();
    edges_until(1'b1, n);
    chk(n == 7 * TICK_DIV, "R3", n, 7 * TICK_DIV);

    // R8: short glitch ignored, steady change after 2+DEB_CYC edges
    cur_req = "R8";
    @(negedge clk) hold1_n = 1'b0;
    wait_n(DEB_CYC - 1);
    hold1_n = 1'b1;
    wait_n(10);
    chk(clk_en == 1'b1, "R8", int'(clk_en), 1);
    hold1_n = 1'b0;
    edges_until(1'b0, n);
    chk(n == 2 + DEB_CYC, "R8", n, 2 + DEB_CYC);

    // R4: freeze gates the enable and pauses the wait
    cur_req = "R4";
    wait_n(5);
    chk(clk_en == 1'b0, "R4", int'(clk_en), 0);
    hold1_n = 1'b1;
    wait_n(12);
    chk(clk_en == 1'b1, "R4", int'(clk_en), 1);
    delay_val = 8'd6;
    pulse_zero();
    wait_n(3);
    hold1_n = 1'b0;
    wait_n(20);
    chk(clk_en == 1'b0, "R4", int'(clk_en), 0);
    hold1_n = 1'b1;
    wait_n(30);
    chk(clk_en == 1'b1, "R4", int'(clk_en), 1);

    // R5: park at ZERO
    cur_req = "R5";
    hold2_n = 1'b0;
    wait_n(8);
    chk(clk_en == 1'b1, "R5", int'(clk_en), 1);
    pulse_zero();
    chk(clk_en == 1'b0, "R5", int'(clk_en), 0);
    wait_n(40);
    chk(clk_en == 1'b0, "R5", int'(clk_en), 0);

    // R6: trigger releases one conversion only
    cur_req = "R6";
    @(negedge clk) trig_n = 1'b0;
    edges_until(1'b1, n);
    chk(n == 3 + DEB_CYC, "R6", n, 3 + DEB_CYC);
    wait_n(5);
    pulse_zero();
    wait_n(20);
    chk(clk_en == 1'b0, "R6", int'(clk_en), 0);
    trig_n = 1'b1;
    wait_n(10);
    chk(clk_en == 1'b0, "R6", int'(clk_en), 0);
    trig_n = 1'b0;
    wait_n(10);
    chk(clk_en == 1'b1, "R6", int'(clk_en), 1);
    trig_n = 1'b1;
    wait_n(8);
    trig_n = 1'b0;           // edge lands while running: ignored
    wait_n(10);
    pulse_zero();
    wait_n(10);
    chk(clk_en == 1'b0, "R6", int'(clk_en), 0);
    trig_n = 1'b1;

    // R7: releasing park resumes
    cur_req = "R7";
    wait_n(6);
    hold2_n = 1'b1;
    edges_until(1'b1, n);
    chk(n == 3 + DEB_CYC, "R7", n, 3 + DEB_CYC);

    // R9: park during a timed wait overrides the timer
    cur_req = "R9";
    wait_n(4);
    delay_val = 8'd10;
    pulse_zero();
    wait_n(4);
    hold2_n = 1'b0;
    wait_n(40);
    chk(clk_en == 1'b0, "R9", int'(clk_en), 0);
    cur_req = "R6";
    trig_n = 1'b0;
    wait_n(10);
    chk(clk_en == 1'b1, "R6", int'(clk_en), 1);
    trig_n = 1'b1;
    hold2_n = 1'b1;
    wait_n(10);
    cur_req = "R1";
    chk(clk_en == 1'b1, "R1", int'(clk_en), 1);

    summary();
  end

endmodule